// File: doc/BRIEF.md
# Multi-Port Reservation Station Scheduler

This block holds micro-operations that have been decoded and renamed but not yet started, and hands them to five execution ports. Each waiting entry records which port it must use, two source tags with a ready flag each, a destination tag, a sequence number and an age count. An entry becomes eligible once both sources are ready. It goes out only if its port is not busy in that cycle. Result tags broadcast on two lanes wake matching sources in the cycle they appear. An entry stays in the pool until it is issued or flushed.

Each port picks at most one eligible entry per cycle, so up to five entries leave together. Among the entries competing for one port, the one that has waited longest wins. This gives an approximation of first-in, first-out order within each port, while work across the pool still flows in dataflow order rather than program order. A flush removes every entry whose sequence number is strictly greater than a supplied value. The front end watches the full flag and inserts at most one entry per cycle.

Top module: `rs_sched`

## Requirements
- R1: While reset is held low at a clock edge the pool empties: `full` is 0 and `iss_valid` is 0 on the next cycle.
- R2: An insert with `full` low is stored at the clock edge. The earliest an entry can issue is the cycle after its insert, with its destination and source tags on the issue port it named.
- R3: An entry whose sources are not both ready never issues.
- R4: A broadcast on either of the two lanes (lane 0 in bits [5:0], lane 1 in bits [11:6] of `bc_tag`) marks matching sources ready in the same cycle. An entry whose last source is woken can issue in that cycle.
- R5: An insert whose not-ready source tag matches a broadcast in the same cycle is stored as ready and can issue on the next cycle.
- R6: While `port_busy[p]` is 1, port p issues nothing and its entries keep waiting.
- R7: Each port issues at most one entry per cycle, and all five ports can issue in the same cycle.
- R8: Among eligible entries for one port, the entry inserted earliest issues first.
- R9: An issued entry leaves the pool and is never issued again.
- R10: `full` is 1 when all 16 entries are occupied, and an insert while `full` is 1 is dropped.
- R11: In a cycle with `flush_valid` high, nothing issues and no insert is accepted. Every entry with a sequence number greater than `flush_seq` (unsigned compare) is removed.
- R12: A younger ready entry issues ahead of an older entry on the same port that is still waiting for an operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_port | input | 3 | Target execution port, 0 to 4 |
| ins_src0_tag | input | 6 | First source tag |
| ins_src0_rdy | input | 1 | First source already available |
| ins_src1_tag | input | 6 | Second source tag |
| ins_src1_rdy | input | 1 | Second source already available |
| ins_dst_tag | input | 6 | Destination tag |
| ins_seq | input | 6 | Sequence number used by flush |
| bc_valid | input | 2 | Broadcast lane valid flags |
| bc_tag | input | 12 | Broadcast result tags, lane 0 in the low bits |
| port_busy | input | 5 | Port p cannot accept work this cycle |
| flush_valid | input | 1 | Flush request |
| flush_seq | input | 6 | Entries with a larger sequence number are removed |
| iss_valid | output | 5 | Port p issues this cycle |
| iss_dst | output | 30 | Destination tag per port, port p at bits [6p+5:6p] |
| iss_src0 | output | 30 | First source tag per port |
| iss_src1 | output | 30 | Second source tag per port |
| full | output | 1 | All entries occupied |

## Verification
The assertions check the following on every cycle: no port grants more than one entry, a busy port grants nothing, a granted entry had both operands ready, and an issued or flushed entry is gone on the next cycle. They also check that a flush cycle issues nothing and that a dropped insert leaves the pool full. Oldest-first order among competitors, same-cycle wakeup from either lane, the ready-on-insert bypass and the out-of-order pass of a stalled older entry need a known stimulus history. Only the bench's directed scenarios can show those.

// File: rtl/rs_pkg.sv
// Package: default sizes shared by the scheduler and its sub-blocks.
// Assumes nothing; holds constants only.
package rs_pkg;
    localparam int RS_ENTRIES = 16;
    localparam int RS_PORTS   = 5;
    localparam int RS_TAG_W   = 6;
    localparam int RS_SEQ_W   = 6;
    localparam int RS_AGE_W   = 8;
    localparam int RS_LANES   = 2;
endpackage

// File: rtl/rs_entry.sv
// Module: one pool slot. Holds port, two source tags with ready flags,
// destination, sequence and a saturating age count. Wakes its sources
// combinationally from the broadcast lanes and raises a request on the
// one port it targets. Assumes alloc only arrives while the slot is empty.
module rs_entry #(
    parameter int PORTS  = rs_pkg::RS_PORTS,
    parameter int TAG_W  = rs_pkg::RS_TAG_W,
    parameter int SEQ_W  = rs_pkg::RS_SEQ_W,
    parameter int AGE_W  = rs_pkg::RS_AGE_W,
    parameter int LANES  = rs_pkg::RS_LANES,
    localparam int PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc,
    input  logic [PORT_W-1:0]      ins_port,
    input  logic [TAG_W-1:0]       ins_s0_tag,
    input  logic                   ins_s0_rdy,
    input  logic [TAG_W-1:0]       ins_s1_tag,
    input  logic                   ins_s1_rdy,
    input  logic [TAG_W-1:0]       ins_dst,
    input  logic [SEQ_W-1:0]       ins_seq,
    input  logic [LANES-1:0]       bc_valid,
    input  logic [LANES*TAG_W-1:0] bc_tag,
    input  logic                   issued,
    input  logic                   flush_valid,
    input  logic [SEQ_W-1:0]       flush_seq,
    output logic                   valid_o,
    output logic [PORTS-1:0]       req_o,
    output logic [AGE_W-1:0]       age_o,
    output logic [TAG_W-1:0]       dst_o,
    output logic [TAG_W-1:0]       s0_o,
    output logic [TAG_W-1:0]       s1_o
);
    logic              valid_q;
    logic [PORT_W-1:0] port_q;
    logic [TAG_W-1:0]  s0_tag_q, s1_tag_q, dst_q;
    logic              s0_rdy_q, s1_rdy_q;
    logic [SEQ_W-1:0]  seq_q;
    logic [AGE_W-1:0]  age_q;
    logic              s0_wake, s1_wake, flushed;

    // Returns 1 when any valid broadcast lane carries the given tag.
    function automatic logic lane_hit(input logic [TAG_W-1:0] t,
                                      input logic [LANES-1:0] v,
                                      input logic [LANES*TAG_W-1:0] tags);
        logic h;
        h = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            if (v[l] && (tags[l*TAG_W +: TAG_W] == t)) h = 1'b1;
        end
        return h;
    endfunction

    // Same-cycle wakeup and flush match for the stored entry.
    always_comb begin
        s0_wake = s0_rdy_q | lane_hit(s0_tag_q, bc_valid, bc_tag);
        s1_wake = s1_rdy_q | lane_hit(s1_tag_q, bc_valid, bc_tag);
        flushed = flush_valid && (seq_q > flush_seq);
    end

    // Request the targeted port when both operands are available.
    always_comb begin
        for (int p = 0; p < PORTS; p++) begin
            req_o[p] = valid_q && s0_wake && s1_wake && !flush_valid
                       && (port_q == PORT_W'(p));
        end
    end

    // Slot state: load on alloc, clear on issue or flush, else age and latch wakeups.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            port_q   <= '0;
            s0_tag_q <= '0;
            s1_tag_q <= '0;
            dst_q    <= '0;
            s0_rdy_q <= 1'b0;
            s1_rdy_q <= 1'b0;
            seq_q    <= '0;
            age_q    <= '0;
        end else if (alloc) begin
            valid_q  <= 1'b1;
            port_q   <= ins_port;
            s0_tag_q <= ins_s0_tag;
            s1_tag_q <= ins_s1_tag;
            dst_q    <= ins_dst;
            s0_rdy_q <= ins_s0_rdy | lane_hit(ins_s0_tag, bc_valid, bc_tag);
            s1_rdy_q <= ins_s1_rdy | lane_hit(ins_s1_tag, bc_valid, bc_tag);
            seq_q    <= ins_seq;
            age_q    <= '0;
        end else if (valid_q) begin
            if (issued || flushed) begin
                valid_q <= 1'b0;
            end else begin
                s0_rdy_q <= s0_wake;
                s1_rdy_q <= s1_wake;
                if (age_q != {AGE_W{1'b1}}) age_q <= age_q + 1'b1;
            end
        end
    end

    assign valid_o = valid_q;
    assign age_o   = age_q;
    assign dst_o   = dst_q;
    assign s0_o    = s0_tag_q;
    assign s1_o    = s1_tag_q;

    // R3: a grant from any picker only reaches a slot whose operands are ready.
    assert_issue_needs_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        issued |-> (valid_q && s0_wake && s1_wake));
    // R9: an issued slot is empty on the following cycle.
    assert_gone_after_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        issued |=> !valid_q);
    // R11: a slot younger than the flush point is empty on the following cycle.
    assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && flush_valid && (seq_q > flush_seq)) |=> !valid_q);
endmodule

// File: rtl/rs_alloc.sv
// Module: free-slot finder. Picks the lowest-index empty slot for an insert
// and reports when none is left. Assumes at most one insert per cycle and
// that inserts are dropped during a flush.
module rs_alloc #(
    parameter int ENTRIES = rs_pkg::RS_ENTRIES
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic               ins_valid,
    input  logic               flush_valid,
    output logic [ENTRIES-1:0] alloc,
    output logic               full
);
    logic found;

    // Lowest empty slot gets the insert when one exists.
    always_comb begin
        alloc = '0;
        found = 1'b0;
        full  = &valid;
        for (int e = 0; e < ENTRIES; e++) begin
            if (!valid[e] && !found) begin
                found = 1'b1;
                alloc[e] = ins_valid && !flush_valid;
            end
        end
    end
endmodule

// File: rtl/rs_pick.sv
// Module: per-port selector. Among requesting slots it grants the one with
// the largest age count, lower index winning ties, unless the port is busy.
// Assumes ages of slots inserted on different cycles differ until saturation.
module rs_pick #(
    parameter int ENTRIES = rs_pkg::RS_ENTRIES,
    parameter int AGE_W   = rs_pkg::RS_AGE_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ENTRIES-1:0]       req,
    input  logic [ENTRIES*AGE_W-1:0] ages,
    input  logic                     busy,
    output logic [ENTRIES-1:0]       grant,
    output logic                     gvalid
);
    logic             found;
    logic [AGE_W-1:0] best_age;
    logic [IDX_W-1:0] best_idx;

    // Oldest-first scan over requesting slots.
    always_comb begin
        found    = 1'b0;
        best_age = '0;
        best_idx = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (req[e] && (!found || (ages[e*AGE_W +: AGE_W] > best_age))) begin
                found    = 1'b1;
                best_age = ages[e*AGE_W +: AGE_W];
                best_idx = IDX_W'(e);
            end
        end
        grant  = '0;
        gvalid = found && !busy;
        if (gvalid) grant[best_idx] = 1'b1;
    end

    // R7: no more than one slot granted per port per cycle.
    assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R6: a busy port grants nothing.
    assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (grant == '0));
endmodule

// File: rtl/rs_sched.sv
// Module: reservation station top. Builds the slot array, one selector per
// port and the free-slot finder, then steers each grant's tags onto its
// issue port. Assumes ins_port is below PORTS and issue ports are taken
// combinationally in the same cycle as iss_valid.
module rs_sched #(
    parameter int ENTRIES = rs_pkg::RS_ENTRIES,
    parameter int PORTS   = rs_pkg::RS_PORTS,
    parameter int TAG_W   = rs_pkg::RS_TAG_W,
    parameter int SEQ_W   = rs_pkg::RS_SEQ_W,
    parameter int AGE_W   = rs_pkg::RS_AGE_W,
    parameter int LANES   = rs_pkg::RS_LANES,
    localparam int PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ins_valid,
    input  logic [PORT_W-1:0]      ins_port,
    input  logic [TAG_W-1:0]       ins_src0_tag,
    input  logic                   ins_src0_rdy,
    input  logic [TAG_W-1:0]       ins_src1_tag,
    input  logic                   ins_src1_rdy,
    input  logic [TAG_W-1:0]       ins_dst_tag,
    input  logic [SEQ_W-1:0]       ins_seq,
    input  logic [LANES-1:0]       bc_valid,
    input  logic [LANES*TAG_W-1:0] bc_tag,
    input  logic [PORTS-1:0]       port_busy,
    input  logic                   flush_valid,
    input  logic [SEQ_W-1:0]       flush_seq,
    output logic [PORTS-1:0]       iss_valid,
    output logic [PORTS*TAG_W-1:0] iss_dst,
    output logic [PORTS*TAG_W-1:0] iss_src0,
    output logic [PORTS*TAG_W-1:0] iss_src1,
    output logic                   full
);
    logic [ENTRIES-1:0]       ent_valid;
    logic [ENTRIES-1:0]       ent_alloc;
    logic [ENTRIES-1:0]       ent_issued;
    logic [ENTRIES*AGE_W-1:0] age_flat;
    logic [PORTS-1:0]         ent_req   [ENTRIES];
    logic [TAG_W-1:0]         ent_dst   [ENTRIES];
    logic [TAG_W-1:0]         ent_s0    [ENTRIES];
    logic [TAG_W-1:0]         ent_s1    [ENTRIES];
    logic [ENTRIES-1:0]       port_req  [PORTS];
    logic [ENTRIES-1:0]       port_gnt  [PORTS];

    rs_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .valid       (ent_valid),
        .ins_valid   (ins_valid),
        .flush_valid (flush_valid),
        .alloc       (ent_alloc),
        .full        (full)
    );

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        rs_entry #(
            .PORTS (PORTS), .TAG_W (TAG_W), .SEQ_W (SEQ_W),
            .AGE_W (AGE_W), .LANES (LANES)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc       (ent_alloc[e]),
            .ins_port    (ins_port),
            .ins_s0_tag  (ins_src0_tag),
            .ins_s0_rdy  (ins_src0_rdy),
            .ins_s1_tag  (ins_src1_tag),
            .ins_s1_rdy  (ins_src1_rdy),
            .ins_dst     (ins_dst_tag),
            .ins_seq     (ins_seq),
            .bc_valid    (bc_valid),
            .bc_tag      (bc_tag),
            .issued      (ent_issued[e]),
            .flush_valid (flush_valid),
            .flush_seq   (flush_seq),
            .valid_o     (ent_valid[e]),
            .req_o       (ent_req[e]),
            .age_o       (age_flat[e*AGE_W +: AGE_W]),
            .dst_o       (ent_dst[e]),
            .s0_o        (ent_s0[e]),
            .s1_o        (ent_s1[e])
        );
    end

    // Regroup slot requests by port for the selectors.
    always_comb begin
        for (int p = 0; p < PORTS; p++) begin
            for (int e = 0; e < ENTRIES; e++) begin
                port_req[p][e] = ent_req[e][p];
            end
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        rs_pick #(.ENTRIES(ENTRIES), .AGE_W(AGE_W)) u_pick (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (port_req[p]),
            .ages   (age_flat),
            .busy   (port_busy[p]),
            .grant  (port_gnt[p]),
            .gvalid (iss_valid[p])
        );
    end

    // A slot leaves when any port grants it.
    always_comb begin
        ent_issued = '0;
        for (int p = 0; p < PORTS; p++) ent_issued = ent_issued | port_gnt[p];
    end

    // Steer the granted slot's tags onto each issue port.
    always_comb begin
        iss_dst  = '0;
        iss_src0 = '0;
        iss_src1 = '0;
        for (int p = 0; p < PORTS; p++) begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (port_gnt[p][e]) begin
                    iss_dst [p*TAG_W +: TAG_W] = iss_dst [p*TAG_W +: TAG_W] | ent_dst[e];
                    iss_src0[p*TAG_W +: TAG_W] = iss_src0[p*TAG_W +: TAG_W] | ent_s0[e];
                    iss_src1[p*TAG_W +: TAG_W] = iss_src1[p*TAG_W +: TAG_W] | ent_s1[e];
                end
            end
        end
    end

    // R11: a flush cycle issues nothing on any port.
    assert_flush_no_issue_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> (iss_valid == '0));
    // R10: an insert arriving while full with no departures leaves the pool full.
    assert_full_drops_insert_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && ins_valid && (iss_valid == '0) && !flush_valid) |=> full);
endmodule

// File: tb/rs_sched_test.sv
module rs_sched_test;
    localparam int TW = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ins_valid;
    logic [2:0]  ins_port;
    logic [5:0]  ins_src0_tag, ins_src1_tag, ins_dst_tag, ins_seq;
    logic        ins_src0_rdy, ins_src1_rdy;
    logic [1:0]  bc_valid;
    logic [11:0] bc_tag;
    logic [4:0]  port_busy;
    logic        flush_valid;
    logic [5:0]  flush_seq;
    logic [4:0]  iss_valid;
    logic [29:0] iss_dst, iss_src0, iss_src1;
    logic        full;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    rs_sched uut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_port(ins_port),
        .ins_src0_tag(ins_src0_tag), .ins_src0_rdy(ins_src0_rdy),
        .ins_src1_tag(ins_src1_tag), .ins_src1_rdy(ins_src1_rdy),
        .ins_dst_tag(ins_dst_tag), .ins_seq(ins_seq),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .port_busy(port_busy),
        .flush_valid(flush_valid), .flush_seq(flush_seq),
        .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_src0(iss_src0),
        .iss_src1(iss_src1), .full(full)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        ins_valid   = 1'b0;
        bc_valid    = 2'b00;
        flush_valid = 1'b0;
    endtask

    task automatic put(input int port, input int t0, input bit r0,
                       input int t1, input bit r1, input int dst, input int seq);
        ins_valid    = 1'b1;
        ins_port     = 3'(port);
        ins_src0_tag = 6'(t0);
        ins_src0_rdy = r0;
        ins_src1_tag = 6'(t1);
        ins_src1_rdy = r1;
        ins_dst_tag  = 6'(dst);
        ins_seq      = 6'(seq);
    endtask

    function automatic logic [5:0] dst_of(input int p);
        return iss_dst[p*TW +: TW];
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; idle(); port_busy = '0; flush_seq = '0;
        put(0, 0, 1, 0, 1, 0, 0); ins_valid = 1'b0;
        bc_tag = '0;
        repeat (3) tick();
        #1;
        chk("R1", "full in reset", 32'(full), 0);
        chk("R1", "iss_valid in reset", 32'(iss_valid), 0);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_basic();
        put(2, 3, 1, 4, 1, 10, 1);
        #1 chk("R2", "no issue in insert cycle", 32'(iss_valid), 0);
        tick(); idle();
        #1 chk("R2", "issue port2", 32'(iss_valid), 32'b00100);
        chk("R2", "dst", 32'(dst_of(2)), 10);
        chk("R2", "src0", 32'(iss_src0[2*TW +: TW]), 3);
        chk("R2", "src1", 32'(iss_src1[2*TW +: TW]), 4);
        tick();
        #1 chk("R9", "removed after issue", 32'(iss_valid), 0);
    endtask

    task automatic t_wake();
        put(1, 5, 0, 2, 1, 11, 2);
        tick(); idle();
        #1 chk("R3", "waits on operand", 32'(iss_valid), 0);
        tick();
        #1 chk("R3", "still waits", 32'(iss_valid), 0);
        bc_valid = 2'b10; bc_tag = {6'd5, 6'd0};
        #1 chk("R4", "lane1 wake issues same cycle", 32'(iss_valid), 32'b00010);
        chk("R4", "dst", 32'(dst_of(1)), 11);
        tick(); idle();
        #1 chk("R9", "gone after wake issue", 32'(iss_valid), 0);
    endtask

    task automatic t_ins_bypass();
        put(0, 7, 0, 1, 1, 12, 3);
        bc_valid = 2'b01; bc_tag = {6'd0, 6'd7};
        #1 chk("R5", "not issued in insert cycle", 32'(iss_valid), 0);
        tick(); idle();
        #1 chk("R5", "ready from insert broadcast", 32'(iss_valid), 32'b00001);
        chk("R5", "dst", 32'(dst_of(0)), 12);
        tick();
    endtask

    task automatic t_busy();
        port_busy = 5'b01000;
        put(3, 1, 1, 1, 1, 13, 4);
        tick(); idle();
        #1 chk("R6", "busy port holds", 32'(iss_valid), 0);
        tick();
        #1 chk("R6", "busy port holds again", 32'(iss_valid), 0);
        port_busy = '0;
        #1 chk("R6", "issues when free", 32'(iss_valid), 32'b01000);
        chk("R6", "dst", 32'(dst_of(3)), 13);
        tick();
    endtask

    task automatic t_five();
        port_busy = 5'b11111;
        for (int p = 0; p < 5; p++) begin
            put(p, 1, 1, 1, 1, 50 + p, 10 + p);
            tick();
        end
        idle();
        port_busy = '0;
        #1 chk("R7", "all five ports issue", 32'(iss_valid), 32'b11111);
        for (int p = 0; p < 5; p++) chk("R7", "per-port dst", 32'(dst_of(p)), 32'(50 + p));
        tick();
        #1 chk("R7", "pool drained", 32'(iss_valid), 0);
    endtask

    task automatic t_oldest();
        port_busy = 5'b10000;
        for (int k = 0; k < 3; k++) begin
            put(4, 1, 1, 1, 1, 20 + k, 20 + k);
            tick();
        end
        idle();
        port_busy = '0;
        for (int k = 0; k < 3; k++) begin
            #1 chk("R8", "oldest first", 32'(dst_of(4)), 32'(20 + k));
            chk("R7", "one per cycle", 32'(iss_valid), 32'b10000);
            tick();
        end
        #1 chk("R8", "drained", 32'(iss_valid), 0);
    endtask

    task automatic t_ooo();
        put(2, 9, 0, 1, 1, 30, 30);
        tick();
        put(2, 1, 1, 1, 1, 31, 31);
        tick(); idle();
        #1 chk("R12", "younger ready passes", 32'(dst_of(2)), 31);
        chk("R12", "port2 issues", 32'(iss_valid), 32'b00100);
        tick();
        #1 chk("R3", "older still waits", 32'(iss_valid), 0);
        bc_valid = 2'b01; bc_tag = {6'd0, 6'd9};
        #1 chk("R4", "lane0 wake", 32'(dst_of(2)), 30);
        tick(); idle();
    endtask

    task automatic t_full();
        port_busy = 5'b11111;
        for (int k = 0; k < 16; k++) begin
            #1 chk("R10", "not full while filling", 32'(full), 0);
            put(0, 1, 1, 1, 1, k, k);
            tick();
        end
        idle();
        #1 chk("R10", "full at 16", 32'(full), 1);
        put(0, 1, 1, 1, 1, 63, 40);
        tick(); idle();
        port_busy = '0;
        for (int k = 0; k < 16; k++) begin
            #1 chk("R10", "drain order", 32'(dst_of(0)), 32'(k));
            chk("R10", "drain valid", 32'(iss_valid), 32'b00001);
            if (k == 1) chk("R10", "full drops", 32'(full), 0);
            tick();
        end
        #1 chk("R10", "dropped insert never issues", 32'(iss_valid), 0);
    endtask

    task automatic t_flush();
        port_busy = 5'b00010;
        for (int k = 0; k < 4; k++) begin
            put(1, 1, 1, 1, 1, 40 + k, 5 + k);
            tick();
        end
        idle();
        port_busy = '0;
        flush_valid = 1'b1; flush_seq = 6'd6;
        put(1, 1, 1, 1, 1, 44, 2);
        #1 chk("R11", "no issue in flush cycle", 32'(iss_valid), 0);
        tick(); idle();
        #1 chk("R11", "seq5 kept", 32'(dst_of(1)), 40);
        tick();
        #1 chk("R11", "seq6 kept", 32'(dst_of(1)), 41);
        chk("R11", "seq6 valid", 32'(iss_valid), 32'b00010);
        tick();
        #1 chk("R11", "younger removed, insert dropped", 32'(iss_valid), 0);
        tick();
        #1 chk("R11", "still empty", 32'(iss_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_wake();
        t_ins_bypass();
        t_busy();
        t_five();
        t_oldest();
        t_ooo();
        t_full();
        t_flush();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule